// File: doc/BRIEF.md
# Packed Colour Palette with Channel Widening

This block keeps a 256-entry colour lookup table in 128 words of 32 bits, with two 16-bit entries in each word. A processor bus reaches the words through a word-addressed read/write window at byte offsets 0x200 to 0x3FF. A read always returns the whole 32-bit word exactly as it was written.

A separate pixel-side port takes an 8-bit colour index and returns 8-bit red, green and blue values one cycle later. Each value comes from a 5-bit field of the selected entry, padded with three zero bits at the bottom. A per-request swap input exchanges the red and blue outputs, for panels wired in blue-green-red order. The storage is a two-port memory with registered reads, so it maps onto a block RAM.

Top module: `clut_palette`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pix_valid` and `bus_rvalid` are 0 and `bus_rdata`, `pix_red`, `pix_green` and `pix_blue` are all zero.
- R2: A write with `bus_wr` high at byte address 0x200+4*k (k from 0 to 127) stores `bus_wdata` in word k. A read with `bus_rd` high gives `bus_rvalid` high in the next cycle, and `bus_rdata` then holds all 32 stored bits, including bits 15 and 31.
- R3: Address bits [1:0] are ignored inside the window. A write whose address lies outside 0x200..0x3FF changes no word. A read outside the window gives `bus_rvalid` high with `bus_rdata` zero.
- R4: Index i selects word i>>1. An even i uses bits [15:0] of that word and an odd i uses bits [31:16].
- R5: Within a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each output is its 5-bit field followed by three zero bits.
- R6: Bit 15 of an entry (the intensity bit) has no effect on the colour outputs.
- R7: When `swap_rb` is high in the cycle of a request, `pix_red` carries the blue field and `pix_blue` carries the red field. Green is unchanged.
- R8: `pix_valid` is high exactly in the cycle after a cycle with `pix_req` high. While `pix_valid` is low, the three colour outputs are zero.
- R9: If a bus write and a pixel lookup address the same word in the same cycle, the lookup returns the contents from before the write.
- R10: `bus_rdata` is zero in every cycle in which `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of a bus access |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pix_req | input | 1 | Pixel lookup request |
| pix_idx | input | 8 | Palette index of the lookup |
| swap_rb | input | 1 | Exchange red and blue for this lookup |
| pix_valid | output | 1 | Colour outputs valid |
| pix_red | output | 8 | Widened red value |
| pix_green | output | 8 | Widened green value |
| pix_blue | output | 8 | Widened blue value |

## Verification
The assertions check the timing on every cycle. Read and lookup strobes must produce their valid flags one cycle later. Outputs must stay zero while their flags are low. A word written on one cycle must be returned by a read of the same word issued on the next. Only the bench scenarios can show the data side: which half-word an index picks, where the fields sit, that the intensity bit has no effect, the red/blue exchange, out-of-window accesses, and the old-data result when a write and a lookup hit the same word.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int FIELD_W = 5;
  localparam int COLOR_W = 8;
  localparam int ENTRY_W = 16;
  localparam int WORD_W  = 2 * ENTRY_W;
  localparam int PAD_W   = COLOR_W - FIELD_W;

  typedef struct packed {
    logic               ibit;
    logic [FIELD_W-1:0] blu;
    logic [FIELD_W-1:0] grn;
    logic [FIELD_W-1:0] red;
  } entry_t;

  function automatic logic [COLOR_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first on both ports: a read in the cycle of a write sees the old word
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

  // R2: a word written in one cycle is returned by a read of it in the next
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(a_we, 2) && ($past(a_addr) == $past(a_addr, 2)))
      |-> (a_rdata == $past(a_wdata, 2)));
endmodule

// File: rtl/clut_bus_port.sv
module clut_bus_port #(
  parameter int              ADDR_W = 12,
  parameter logic [11:0]     BASE   = 12'h200,
  parameter int              WORDS  = 128,
  parameter int              IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       ram_rdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int LO_BYTE = int'(BASE);
  localparam int HI_BYTE = LO_BYTE + WORDS * 4;

  logic              hit;
  logic              hit_q;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    hit     = (int'(bus_addr) >= LO_BYTE) && (int'(bus_addr) < HI_BYTE);
    offs    = bus_addr - BASE[ADDR_W-1:0];
    ram_idx = offs[IDX_W+1:2];
    ram_we  = bus_wr && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      hit_q      <= hit;
    end
  end

  assign bus_rdata = (bus_rvalid && hit_q) ? ram_rdata : '0;

  // R2: read data valid follows the read strobe by one cycle
  p_rvalid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_rvalid == $past(bus_rd)));

  // R10: no data is shown without the valid flag
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0));
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               hi_half,
  input  logic               swap,
  input  logic               valid,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);
  entry_t ent;

  always_comb begin
    ent = entry_t'(word[(hi_half ? ENTRY_W : 0) +: ENTRY_W]);
    if (!valid) begin
      red   = '0;
      green = '0;
      blue  = '0;
    end else begin
      green = widen(ent.grn);
      red   = swap ? widen(ent.blu) : widen(ent.red);
      blue  = swap ? widen(ent.red) : widen(ent.blu);
    end
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'h200,
  parameter int          WORDS  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              pix_req,
  input  logic [7:0]        pix_idx,
  input  logic              swap_rb,
  output logic              pix_valid,
  output logic [7:0]        pix_red,
  output logic [7:0]        pix_green,
  output logic [7:0]        pix_blue
);
  localparam int IDX_W = $clog2(WORDS);

  logic              ram_we;
  logic [IDX_W-1:0]  ram_idx;
  logic [31:0]       ram_a_q;
  logic [31:0]       ram_b_q;
  logic              half_q;
  logic              swap_q;

  clut_bus_port #(
    .ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS), .IDX_W(IDX_W)
  ) u_bus (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .ram_rdata(ram_a_q), .ram_we(ram_we),
    .ram_idx(ram_idx), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  clut_ram #(.DEPTH(WORDS), .DATA_W(WORD_W), .AW(IDX_W)) u_ram (
    .clk(clk), .rst(rst), .a_we(ram_we), .a_addr(ram_idx),
    .a_wdata(bus_wdata), .a_rdata(ram_a_q),
    .b_addr(pix_idx[IDX_W:1]), .b_rdata(ram_b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      half_q    <= 1'b0;
      swap_q    <= 1'b0;
    end else begin
      pix_valid <= pix_req;
      half_q    <= pix_idx[0];
      swap_q    <= swap_rb;
    end
  end

  clut_expand u_exp (
    .word(ram_b_q), .hi_half(half_q), .swap(swap_q), .valid(pix_valid),
    .red(pix_red), .green(pix_green), .blue(pix_blue)
  );

  // R8: lookup result flag one cycle after the request
  p_pix_lat_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pix_valid == $past(pix_req)));

  // R8: colour outputs quiet while no result is presented
  p_pix_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ((pix_red == '0) && (pix_green == '0) && (pix_blue == '0)));
endmodule

// File: tb/sim_clut_palette.sv
module sim_clut_palette;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        pix_req = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        swap_rb = 1'b0;
  logic        pix_valid;
  logic [7:0]  pix_red, pix_green, pix_blue;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [31:0] shadow [128];

  always #2.5 clk = ~clk;

  clut_palette u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pix_req(pix_req), .pix_idx(pix_idx),
    .swap_rb(swap_rb), .pix_valid(pix_valid), .pix_red(pix_red),
    .pix_green(pix_green), .pix_blue(pix_blue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [7:0] idx, input logic sw);
    logic [31:0] w;
    logic [15:0] e;
    logic [7:0]  r, g, b;
    w = shadow[idx[7:1]];
    e = idx[0] ? w[31:16] : w[15:0];
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic lookup(input string req, input logic [7:0] idx, input logic sw);
    @(negedge clk);
    pix_req = 1'b1; pix_idx = idx; swap_rb = sw;
    @(negedge clk);
    pix_req = 1'b0; swap_rb = 1'b0;
    chk({req, " valid"}, 32'(pix_valid), 32'd1);
    chk({req, " colour"}, {8'h0, pix_red, pix_green, pix_blue}, {8'h0, model(idx, sw)});
    @(negedge clk);
    chk("R8 idle zero", {7'h0, pix_valid, pix_red, pix_green, pix_blue}, 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in reset", {bus_rvalid, pix_valid, 6'h0, pix_red, pix_green, pix_blue}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {bus_rvalid, pix_valid, 6'h0, pix_red, pix_green, pix_blue}, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] d; logic v;
    bus_write(12'h200, 32'h8000_7FFF); shadow[0]   = 32'h8000_7FFF;
    bus_write(12'h204, 32'hA5C3_1E69); shadow[1]   = 32'hA5C3_1E69;
    bus_write(12'h3FC, 32'hFFFF_8001); shadow[127] = 32'hFFFF_8001;
    bus_read(12'h200, d, v);
    chk("R2 rvalid", 32'(v), 32'd1);
    chk("R2 word0 incl bit31", d, 32'h8000_7FFF);
    bus_read(12'h3FC, d, v);
    chk("R2 word127", d, 32'hFFFF_8001);
    bus_read(12'h206, d, v);
    chk("R3 low bits ignored", d, 32'hA5C3_1E69);
    @(negedge clk);
    chk("R10 rdata idle", bus_rdata, 32'h0);
  endtask

  task automatic t_outside();
    logic [31:0] d; logic v;
    bus_write(12'h400, 32'h1234_5678);
    bus_write(12'h1FC, 32'h1234_5678);
    bus_read(12'h200, d, v);
    chk("R3 word0 untouched", d, shadow[0]);
    bus_read(12'h3FC, d, v);
    chk("R3 word127 untouched", d, shadow[127]);
    bus_read(12'h400, d, v);
    chk("R3 outside rvalid", 32'(v), 32'd1);
    chk("R3 outside data zero", d, 32'h0);
  endtask

  task automatic t_lookup();
    @(negedge clk);
    pix_req = 1'b1; pix_idx = 8'd3; swap_rb = 1'b0;
    #1;
    chk("R8 no same-cycle valid", 32'(pix_valid), 32'd0);
    pix_req = 1'b0;
    lookup("R4 even half", 8'd2, 1'b0);
    lookup("R4 odd half", 8'd3, 1'b0);
    lookup("R5 full fields", 8'd0, 1'b0);
    lookup("R7 swap", 8'd2, 1'b1);
    lookup("R7 swap odd", 8'd3, 1'b1);
    bus_write(12'h210, 32'h8421_0421); shadow[4] = 32'h8421_0421;
    lookup("R6 ibit low", 8'd8, 1'b0);
    lookup("R6 ibit high", 8'd9, 1'b0);
    chk("R6 halves equal", {8'h0, model(8'd8, 1'b0)}, {8'h0, model(8'd9, 1'b0)});
    lookup("R5 top word", 8'd255, 1'b0);
  endtask

  task automatic t_collide();
    bus_write(12'h214, 32'h0000_001F); shadow[5] = 32'h0000_001F;
    @(negedge clk);
    bus_addr = 12'h214; bus_wdata = 32'h0000_7C00; bus_wr = 1'b1;
    pix_req = 1'b1; pix_idx = 8'd10;
    @(negedge clk);
    bus_wr = 1'b0; pix_req = 1'b0;
    chk("R9 old contents", {8'h0, pix_red, pix_green, pix_blue}, 32'h00F8_0000);
    shadow[5] = 32'h0000_7C00;
    lookup("R9 new contents after", 8'd10, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bus();
    t_outside();
    t_lookup();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R8 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule